// File: doc/BRIEF.md
# Two-Rank Converter Update Sequencer

This block takes a stream of bytes and turns each group of four into one write to a shared converter bus. Up to sixteen channel controllers sit on that bus, and each one serves up to sixteen converters. Every converter has two ranks of storage. A select strobe loads the first rank of one converter. A common convert line copies the first rank into the second rank in all converters at the same moment, so only the converters whose first rank was rewritten show a new output.

The 2-bit code in each record decides what follows the load. The code can load the first rank and stop there. It can load and then pulse the convert line at once. It can also load and then stop taking bytes until an external transfer trigger arrives, and that trigger then produces the convert pulse.

A start pulse loads a record count. The block raises a channel-end flag when it begins the load of the last record. It stops with an unusual-end flag on a halt request. It also stops with unusual-end and a rate-error flag when the external trigger arrives while the block is not waiting for it.

Top module: `dacu_top`

## Requirements
- R1: A record is four bytes taken in this order: control, address, data high byte, data low byte. A byte is taken on a clock edge where both `inValid` and `inReady` are high. `inReady` is high only while a record is being fetched.
- R2: Control code bits [1:0] equal to 00 or 10 load the addressed first rank and give no convert pulse. Control bits [7:2] have no effect.
- R3: Control code 01 loads the addressed first rank. A convert pulse of CONV_CYC cycles then starts in the cycle right after the select strobe ends.
- R4: The select strobe is high for exactly STROBE_CYC cycles and starts in the cycle after the last data byte is taken. `busSel` and `busData` stay stable while the strobe is high. `busSel[7:4]` selects the channel controller and `busSel[3:0]` selects the converter. `busData` is the data word with the high byte in [15:8].
- R5: Control code 11 loads the addressed first rank and then holds `inReady` and `convert` low. When `extTrig` is sampled high, a convert pulse starts in the next cycle and fetching resumes after that pulse.
- R6: `start` while idle loads `recCount`. `busy` stays high until the last record has finished its strobe and any convert pulse. `chanEnd` rises together with the select strobe of the last record. A count of zero sets `chanEnd` and leaves the block idle.
- R7: `halt` while busy returns the block to idle in the next cycle and sets `unusualEnd`. No further strobe follows.
- R8: `extTrig` while busy and not waiting under code 11 sets `rateErr` and `unusualEnd` and returns the block to idle. `extTrig` while idle changes no flag and gives no convert pulse.
- R9: `start` clears `chanEnd`, `unusualEnd` and `rateErr`. The flags otherwise hold their values while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run of records (taken only while idle) |
| recCount | input | CNT_W | Number of records in the run |
| halt | input | 1 | Abort request |
| inByte | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte present |
| inReady | output | 1 | Block takes a byte this cycle |
| extTrig | input | 1 | External transfer trigger |
| busData | output | 16 | Converter data word |
| busSel | output | 8 | Channel controller (upper nibble) and converter (lower nibble) |
| selStrobe | output | 1 | First-rank load strobe |
| convert | output | 1 | Common first-to-second rank transfer |
| busy | output | 1 | A run is in progress |
| chanEnd | output | 1 | Last record started its load |
| unusualEnd | output | 1 | Run ended by halt or rate error |
| rateErr | output | 1 | Trigger arrived while not waiting |

## Verification
The select strobe rises one cycle after the edge that takes the data low byte. A code 01 convert pulse rises in the cycle after the strobe's last cycle. A code 11 convert pulse rises one cycle after `extTrig` is sampled. Halt and rate-error aborts show on the flags and on `busy` one cycle after the request. The bench drives its inputs on falling edges and samples on falling edges. It checks each of these results at that exact falling edge by counting edges from the stimulus. A monitor keeps a two-rank model of every converter. It compares each strobe against a queue of expected writes and checks each convert pulse against a count of the pulses it expects.

// File: rtl/dacu_pkg.sv
package dacu_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDR,
    S_DHI,
    S_DLO,
    S_STROBE,
    S_CONV,
    S_WAIT
  } seqState_t;

  // capture strobes from control to datapath
  typedef struct packed {
    logic capCtrl;
    logic capAddr;
    logic capHi;
    logic capLo;
  } capStrobes_t;

  localparam logic [1:0] CODE_LOAD  = 2'b00;
  localparam logic [1:0] CODE_XFER  = 2'b01;
  localparam logic [1:0] CODE_STALL = 2'b11;

endpackage

// File: rtl/dacu_datapath.sv
module dacu_datapath
  import dacu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inByte,
  input  capStrobes_t strb,
  output logic [1:0]  code,
  output logic [15:0] busData,
  output logic [7:0]  busSel
);

  logic [1:0]  codeReg;
  logic [7:0]  selReg;
  logic [15:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= '0;
      selReg  <= '0;
      dataReg <= '0;
    end else begin
      if (strb.capCtrl) codeReg       <= inByte[1:0];
      if (strb.capAddr) selReg        <= inByte;
      if (strb.capHi)   dataReg[15:8] <= inByte;
      if (strb.capLo)   dataReg[7:0]  <= inByte;
    end
  end

  assign code    = codeReg;
  assign busSel  = selReg;
  assign busData = dataReg;

  // R1: at most one byte slot captured per cycle
  a_r1_one_capture: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/dacu_ctrl.sv
module dacu_ctrl
  import dacu_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int STROBE_CYC = 250,
  parameter int CONV_CYC   = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] recCount,
  input  logic             halt,
  input  logic             inValid,
  input  logic             extTrig,
  input  logic [1:0]       code,
  output logic             inReady,
  output capStrobes_t      strb,
  output logic             selStrobe,
  output logic             convert,
  output logic             busy,
  output logic             chanEnd,
  output logic             unusualEnd,
  output logic             rateErr
);

  localparam int MAX_CYC = (STROBE_CYC > CONV_CYC) ? STROBE_CYC : CONV_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  seqState_t        state;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] remaining;
  logic             accept;

  assign inReady = (state == S_CTRL) || (state == S_ADDR) ||
                   (state == S_DHI)  || (state == S_DLO);
  assign accept  = inValid && inReady;

  always_comb begin
    strb         = '0;
    strb.capCtrl = accept && (state == S_CTRL);
    strb.capAddr = accept && (state == S_ADDR);
    strb.capHi   = accept && (state == S_DHI);
    strb.capLo   = accept && (state == S_DLO);
  end

  assign selStrobe = (state == S_STROBE);
  assign convert   = (state == S_CONV);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      timer      <= '0;
      remaining  <= '0;
      chanEnd    <= 1'b0;
      unusualEnd <= 1'b0;
      rateErr    <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start) begin
        unusualEnd <= 1'b0;
        rateErr    <= 1'b0;
        remaining  <= recCount;
        if (recCount == '0) begin
          chanEnd <= 1'b1;
        end else begin
          chanEnd <= 1'b0;
          state   <= S_CTRL;
        end
      end
    end else if (halt) begin
      unusualEnd <= 1'b1;
      state      <= S_IDLE;
    end else if (extTrig && state != S_WAIT) begin
      rateErr    <= 1'b1;
      unusualEnd <= 1'b1;
      state      <= S_IDLE;
    end else begin
      unique case (state)
        S_CTRL: if (accept) state <= S_ADDR;
        S_ADDR: if (accept) state <= S_DHI;
        S_DHI:  if (accept) state <= S_DLO;
        S_DLO: begin
          if (accept) begin
            state     <= S_STROBE;
            timer     <= TMR_W'(STROBE_CYC - 1);
            remaining <= remaining - 1'b1;
            if (remaining == CNT_W'(1)) chanEnd <= 1'b1;
          end
        end
        S_STROBE: begin
          if (timer == '0) begin
            if (code == CODE_XFER) begin
              state <= S_CONV;
              timer <= TMR_W'(CONV_CYC - 1);
            end else if (code == CODE_STALL) begin
              state <= S_WAIT;
            end else begin
              state <= (remaining == '0) ? S_IDLE : S_CTRL;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_WAIT: begin
          if (extTrig) begin
            state <= S_CONV;
            timer <= TMR_W'(CONV_CYC - 1);
          end
        end
        S_CONV: begin
          if (timer == '0) state <= (remaining == '0) ? S_IDLE : S_CTRL;
          else             timer <= timer - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3, R5: a convert pulse begins only after a code-01 strobe or a trigger while stalled
  a_r3_convert_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convert) |->
      ($past(state) == S_STROBE && $past(code) == CODE_XFER) ||
      ($past(state) == S_WAIT && $past(extTrig)));

  // R5: while stalled with no trigger and no halt, the stall persists
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !extTrig && !halt) |=> (state == S_WAIT && !inReady));

  // R8: a rate error always follows a trigger and carries unusual end
  a_r8_rate_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rateErr) |-> ($past(extTrig) && unusualEnd && !busy));

  // R6: channel end rises only once the record count is used up
  a_r6_chanend_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanEnd) |-> (remaining == '0));

endmodule

// File: rtl/dacu_top.sv
module dacu_top
  import dacu_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int STROBE_CYC = 250,
  parameter int CONV_CYC   = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] recCount,
  input  logic             halt,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  output logic             inReady,
  input  logic             extTrig,
  output logic [15:0]      busData,
  output logic [7:0]       busSel,
  output logic             selStrobe,
  output logic             convert,
  output logic             busy,
  output logic             chanEnd,
  output logic             unusualEnd,
  output logic             rateErr
);

  capStrobes_t strb;
  logic [1:0]  code;

  dacu_ctrl #(
    .CNT_W(CNT_W), .STROBE_CYC(STROBE_CYC), .CONV_CYC(CONV_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .recCount(recCount), .halt(halt),
    .inValid(inValid), .extTrig(extTrig), .code(code), .inReady(inReady),
    .strb(strb), .selStrobe(selStrobe), .convert(convert), .busy(busy),
    .chanEnd(chanEnd), .unusualEnd(unusualEnd), .rateErr(rateErr)
  );

  dacu_datapath u_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .strb(strb), .code(code),
    .busData(busData), .busSel(busSel)
  );

  // R4: address and data hold still through the whole strobe
  a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    (selStrobe && $past(selStrobe)) |-> ($stable(busData) && $stable(busSel)));

  // R3: strobe and convert never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(selStrobe && convert));

endmodule

// File: tb/dacu_top_bench.sv
module dacu_top_bench;

  localparam int CNT_W = 8;
  localparam int STB   = 5;
  localparam int CNV   = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] recCount = '0;
  logic             halt = 1'b0;
  logic [7:0]       inByte = '0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic             extTrig = 1'b0;
  logic [15:0]      busData;
  logic [7:0]       busSel;
  logic             selStrobe, convert, busy, chanEnd, unusualEnd, rateErr;

  always #2 clk = ~clk;

  dacu_top #(.CNT_W(CNT_W), .STROBE_CYC(STB), .CONV_CYC(CNV)) u_dacu_top (
    .clk(clk), .rstN(rstN), .start(start), .recCount(recCount), .halt(halt),
    .inByte(inByte), .inValid(inValid), .inReady(inReady), .extTrig(extTrig),
    .busData(busData), .busSel(busSel), .selStrobe(selStrobe), .convert(convert),
    .busy(busy), .chanEnd(chanEnd), .unusualEnd(unusualEnd), .rateErr(rateErr)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // two-rank converter model and scoreboard
  logic [15:0] rank1 [256];
  logic [15:0] rank2 [256];
  logic [23:0] expQ [$];
  int          pendConv = 0;
  logic        prevStb = 1'b0, prevCnv = 1'b0;
  int          stbLen = 0, cnvLen = 0;
  logic [23:0] item;

  initial for (int i = 0; i < 256; i++) begin rank1[i] = '0; rank2[i] = '0; end

  always @(negedge clk) begin
    if (rstN) begin
      if (selStrobe && !prevStb) begin
        if (expQ.size() == 0) check(1'b0, "R2 unexpected strobe", int'(busSel), 0);
        else begin
          item = expQ.pop_front();
          check({busSel, busData} == item, "R1/R4 strobe sel+data", int'({busSel, busData}), int'(item));
        end
        rank1[busSel] = busData;
        stbLen = 1;
      end else if (selStrobe) stbLen++;
      if (!selStrobe && prevStb) check(stbLen == STB, "R4 strobe width", stbLen, STB);
      if (convert && !prevCnv) begin
        check(pendConv > 0, "R2/R3 unexpected convert", pendConv, 1);
        if (pendConv > 0) pendConv--;
        for (int i = 0; i < 256; i++) rank2[i] = rank1[i];
        cnvLen = 1;
      end else if (convert) cnvLen++;
      if (!convert && prevCnv) check(cnvLen == CNV, "R3 convert width", cnvLen, CNV);
    end
    prevStb = selStrobe;
    prevCnv = convert;
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic sendRecord(input logic [7:0] c, input logic [7:0] a, input logic [15:0] d);
    expQ.push_back({a, d});
    if (c[1:0] == 2'b01 || c[1:0] == 2'b11) pendConv++;
    sendByte(c);
    sendByte(a);
    sendByte(d[15:8]);
    sendByte(d[7:0]);
  endtask

  task automatic doStart(input int n);
    @(negedge clk);
    start = 1'b1;
    recCount = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(!busy && !inReady && !selStrobe && !convert, "R1 reset outputs", int'(busy), 0);
    check(!chanEnd && !unusualEnd && !rateErr, "R9 reset flags", int'({chanEnd, unusualEnd, rateErr}), 0);

    // run of four records
    doStart(4);
    check(busy && inReady && !chanEnd, "R6 start busy", int'({busy, inReady, chanEnd}), 3'b110);
    sendRecord(8'h00, 8'h23, 16'h8001);
    sendRecord(8'hFC, 8'h5F, 16'h7FFE);   // R2 upper control bits ignored
    sendRecord(8'h02, 8'h23, 16'h1234);   // R2 code 10 acts as 00
    repeat (STB + 2) @(negedge clk);
    check(!chanEnd, "R6 chanEnd not early", int'(chanEnd), 0);
    check(rank2[8'h23] == 16'h0000, "R2 no transfer on load-only", int'(rank2[8'h23]), 0);
    check(rank1[8'h23] == 16'h1234, "R2 first rank loaded", int'(rank1[8'h23]), 16'h1234);
    sendRecord(8'h01, 8'h40, 16'hFFFF);
    @(negedge clk);
    check(selStrobe && chanEnd, "R6 chanEnd with last strobe", int'({selStrobe, chanEnd}), 2'b11);
    repeat (STB) @(negedge clk);
    check(convert && !selStrobe, "R3 convert right after strobe", int'({convert, selStrobe}), 2'b10);
    waitIdle();
    check(rank2[8'h23] == 16'h1234 && rank2[8'h5F] == 16'h7FFE && rank2[8'h40] == 16'hFFFF,
          "R3 transfer into second rank", int'(rank2[8'h5F]), 16'h7FFE);
    check(rank2[8'h41] == 16'h0000, "R3 untouched converter unchanged", int'(rank2[8'h41]), 0);
    check(chanEnd && !unusualEnd && !rateErr, "R6 clean end flags", int'({chanEnd, unusualEnd, rateErr}), 3'b100);

    // stall under code 11
    doStart(2);
    sendRecord(8'h03, 8'h11, 16'h0100);
    repeat (STB + 3) @(negedge clk);
    check(!inReady && !convert && busy, "R5 stalled", int'({inReady, convert, busy}), 3'b001);
    repeat (5) @(negedge clk);
    check(!inReady && !convert, "R5 still stalled", int'({inReady, convert}), 0);
    extTrig = 1'b1;
    @(negedge clk);
    extTrig = 1'b0;
    check(convert, "R5 convert after trigger", int'(convert), 1);
    sendRecord(8'h00, 8'h12, 16'h5555);
    waitIdle();
    check(rank2[8'h11] == 16'h0100 && rank2[8'h12] == 16'h0000, "R5 second rank after stall",
          int'(rank2[8'h11]), 16'h0100);

    // trigger while idle has no effect
    extTrig = 1'b1;
    @(negedge clk);
    extTrig = 1'b0;
    repeat (3) @(negedge clk);
    check(!convert && !rateErr && !unusualEnd && chanEnd, "R8 idle trigger ignored",
          int'({convert, rateErr, unusualEnd, chanEnd}), 4'b0001);

    // halt mid-record
    doStart(3);
    check(!chanEnd, "R9 start clears chanEnd", int'(chanEnd), 0);
    sendRecord(8'h00, 8'h70, 16'h0A0A);
    sendByte(8'h01);
    sendByte(8'h71);
    @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    check(unusualEnd && !busy && !rateErr && !inReady, "R7 halt aborts",
          int'({unusualEnd, busy, rateErr, inReady}), 4'b1000);
    repeat (20) @(negedge clk);
    check(!selStrobe && !convert, "R7 nothing after halt", int'({selStrobe, convert}), 0);

    // rate error between records
    doStart(2);
    check(!unusualEnd && !rateErr, "R9 start clears error flags", int'({unusualEnd, rateErr}), 0);
    sendRecord(8'h00, 8'h33, 16'h4444);
    repeat (STB + 2) @(negedge clk);
    extTrig = 1'b1;
    @(negedge clk);
    extTrig = 1'b0;
    check(rateErr && unusualEnd && !busy, "R8 rate error", int'({rateErr, unusualEnd, busy}), 3'b110);

    // zero count
    doStart(0);
    check(chanEnd && !busy && !rateErr, "R6 zero count", int'({chanEnd, busy, rateErr}), 3'b100);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R1 all expected strobes seen", expQ.size(), 0);
    check(pendConv == 0, "R3/R5 all expected converts seen", pendConv, 0);
    finishRun();
  end

endmodule